// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This block turns one scalar instruction into a stream of per-element operations, acting as a loop unrolled in hardware. Each instruction has up to three operand register fields, each 5 bits wide. Each field is looked up in a 32-entry tag table. A tag says whether the register is vectorised, which physical register (0 to 127) it really names, and the width of each element. Two architectural registers may name the same physical register. For each enabled element, the block hands an operation to a multi-issue instruction queue over a valid/ready handshake. The operation carries the element index, one 7-bit physical register number per operand, and one byte offset per operand inside that 64-bit register.

Elements whose predicate bit is clear never reach the queue. The next enabled element is shown in the same cycle that the skipped one would have taken, so skipped elements cost no cycles. A narrow element width packs several elements into one 64-bit register. The physical register number moves on only when that register's bytes are used up. A new instruction is taken only while `busy` is low. A one-cycle `done` pulse marks the end of every instruction, including one that has nothing to emit.

Top module: `vseq_issue`

## Requirements
- R1: `start` is accepted only in a cycle where `busy` is low. `busy` rises in the cycle after an accepted instruction that has at least one element to emit, and stays high until its last element is handed over. `start` while `busy` is high has no effect on the sequence.
- R2: For a vectorised operand, element i uses physical register (redirect + floor(i / E)) mod 128. The width code is 00 = 64-bit, 01 = 32-bit, 10 = 16-bit, 11 = 8-bit, and E is 1, 2, 4 or 8 respectively.
- R3: For a vectorised operand, the byte offset of element i is (i × B) mod 8, where B is 8, 4, 2 or 1 for width codes 00, 01, 10, 11.
- R4: An operand that is not vectorised uses its redirect register, with byte offset 0, for every element.
- R5: When any operand is vectorised, the block emits exactly the indices i < vlen (vlen capped at 64) whose predicate bit i is 1, in ascending order, one per handshake. Valid stays high in every cycle until the last one is taken, with no idle cycles for skipped elements.
- R6: When no operand is vectorised, exactly one operation with index 0 is emitted, whatever the predicate and length.
- R7: A vectorised instruction with no enabled element (vlen 0, or predicate bits all 0 below vlen) emits nothing. It raises `done` in the cycle after acceptance, and `busy` stays low.
- R8: `done` is high for exactly one cycle, the cycle after the last handshake. `busy` is low in that cycle.
- R9: While `op_valid` is high and `op_ready` is low, `op_valid` and all operation fields hold their values into the next cycle.
- R10: Tag contents, operand fields, length and predicate are captured at acceptance. Later changes to those inputs do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Offer a new instruction |
| vlen | input | 7 | Vector length, 0 to 64 |
| pmask | input | 64 | Predicate, bit i enables element i |
| areg | input | 15 | Three 5-bit architectural operand fields, operand k at bits [5k+4:5k] |
| tag_vec | input | 32 | Vectorised flag per architectural register |
| tag_redir | input | 224 | 7-bit redirect target per register, register r at [7r+6:7r] |
| tag_ew | input | 64 | 2-bit width code per register, register r at [2r+1:2r] |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| op_valid | output | 1 | Element operation offered |
| op_ready | input | 1 | Queue accepts the operation |
| op_idx | output | 6 | Element index |
| op_preg | output | 21 | Physical register per operand, operand k at [7k+6:7k] |
| op_boff | output | 9 | Byte offset per operand, operand k at [3k+2:3k] |

## Verification
The operation fields come from registered state through combinational logic alone. The first element is therefore due in the cycle after the accepting edge, and each following element is due in the cycle after the handshake edge that took the previous one. `done` and the fall of `busy` appear in the cycle after the last handshake, or in the cycle after acceptance when nothing is enabled. The bench drives inputs and samples every output on the falling edge. It walks an expected element list computed from a snapshot of the tag table, so each comparison lands in exactly the cycle one register stage after the edge that caused it.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   // element width code: number of elements per 64-bit register is 1 << code
   typedef enum logic [1:0] {
      EW_D = 2'b00,
      EW_W = 2'b01,
      EW_H = 2'b10,
      EW_B = 2'b11
   } ew_e;
endpackage

// File: rtl/vseq_tag_lookup.sv
module vseq_tag_lookup #(
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   localparam int NREG = 1 << AREG_W
) (
   input  logic [AREG_W-1:0]      areg,
   input  logic [NREG-1:0]        tag_vec,
   input  logic [NREG*PREG_W-1:0] tag_redir,
   input  logic [NREG*2-1:0]      tag_ew,
   output logic                   vec,
   output logic [PREG_W-1:0]      base,
   output vseq_pkg::ew_e          ew
);
   always_comb begin
      vec  = tag_vec[areg];
      base = tag_redir[int'(areg)*PREG_W +: PREG_W];
      ew   = vseq_pkg::ew_e'(tag_ew[int'(areg)*2 +: 2]);
   end
endmodule

// File: rtl/vseq_elem_pick.sv
module vseq_elem_pick #(
   parameter int N = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   // lowest set bit wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen #(
   parameter int PREG_W = 7,
   parameter int IDX_W  = 6
) (
   input  logic                vec,
   input  logic [PREG_W-1:0]   base,
   input  vseq_pkg::ew_e       ew,
   input  logic [IDX_W-1:0]    idx,
   output logic [PREG_W-1:0]   preg,
   output logic [2:0]          boff
);
   logic [IDX_W+2:0] scaled;
   logic [IDX_W-1:0] regstep;

   always_comb begin
      // idx * 8 / elems-per-reg, low three bits give the byte lane
      scaled  = {idx, 3'b000} >> ew;
      regstep = idx >> ew;
      preg    = vec ? base + PREG_W'(regstep) : base;
      boff    = vec ? scaled[2:0] : 3'd0;
   end
endmodule

// File: rtl/vseq_issue.sv
module vseq_issue #(
   parameter int NOPS   = 3,
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   parameter int MAXVL  = 64,
   localparam int NREG  = 1 << AREG_W,
   localparam int IDX_W = $clog2(MAXVL),
   localparam int VL_W  = IDX_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [VL_W-1:0]        vlen,
   input  logic [MAXVL-1:0]       pmask,
   input  logic [NOPS*AREG_W-1:0] areg,
   input  logic [NREG-1:0]        tag_vec,
   input  logic [NREG*PREG_W-1:0] tag_redir,
   input  logic [NREG*2-1:0]      tag_ew,
   output logic                   busy,
   output logic                   done,
   output logic                   op_valid,
   input  logic                   op_ready,
   output logic [IDX_W-1:0]       op_idx,
   output logic [NOPS*PREG_W-1:0] op_preg,
   output logic [NOPS*3-1:0]      op_boff
);
   if (NOPS < 1) begin : g_chk_nops
      $error("vseq_issue: NOPS must be at least 1");
   end
   if (MAXVL < 2 || MAXVL > 64 || (1 << IDX_W) != MAXVL) begin : g_chk_vl
      $error("vseq_issue: MAXVL must be a power of two from 2 to 64");
   end
   if (PREG_W < AREG_W) begin : g_chk_preg
      $error("vseq_issue: PREG_W must not be narrower than AREG_W");
   end

   // tag lookups on the offered instruction
   logic [NOPS-1:0]        lk_vec;
   logic [NOPS*PREG_W-1:0] lk_base;
   logic [NOPS*2-1:0]      lk_ew;

   // captured per-operand state
   logic [NOPS-1:0]        vec_q;
   logic [NOPS*PREG_W-1:0] base_q;
   logic [NOPS*2-1:0]      ew_q;
   logic [MAXVL-1:0]       rem_q;
   logic                   busy_q;
   logic                   done_q;

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      vseq_pkg::ew_e lk_ew_e;
      vseq_tag_lookup #(.AREG_W(AREG_W), .PREG_W(PREG_W)) u_lk (
         .areg      (areg[k*AREG_W +: AREG_W]),
         .tag_vec   (tag_vec),
         .tag_redir (tag_redir),
         .tag_ew    (tag_ew),
         .vec       (lk_vec[k]),
         .base      (lk_base[k*PREG_W +: PREG_W]),
         .ew        (lk_ew_e)
      );
      assign lk_ew[k*2 +: 2] = lk_ew_e;

      vseq_addr_gen #(.PREG_W(PREG_W), .IDX_W(IDX_W)) u_ag (
         .vec  (vec_q[k]),
         .base (base_q[k*PREG_W +: PREG_W]),
         .ew   (vseq_pkg::ew_e'(ew_q[k*2 +: 2])),
         .idx  (op_idx),
         .preg (op_preg[k*PREG_W +: PREG_W]),
         .boff (op_boff[k*3 +: 3])
      );
   end

   // elements below the vector length
   logic [MAXVL-1:0] lenmask;
   always_comb begin
      for (int i = 0; i < MAXVL; i++) begin
         lenmask[i] = int'(vlen) > i;
      end
   end

   logic             any_vec;
   logic [MAXVL-1:0] init_rem;
   logic             accept;
   logic             found;
   logic             fire;
   logic [MAXVL-1:0] rem_nxt;

   assign any_vec  = |lk_vec;
   assign init_rem = any_vec ? (pmask & lenmask) : MAXVL'(1);
   assign accept   = start && !busy_q;

   vseq_elem_pick #(.N(MAXVL)) u_pick (
      .req   (rem_q),
      .found (found),
      .idx   (op_idx)
   );

   assign op_valid = busy_q && found;
   assign fire     = op_valid && op_ready;
   assign rem_nxt  = rem_q & (rem_q - MAXVL'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rem_q  <= '0;
         vec_q  <= '0;
         base_q <= '0;
         ew_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            rem_q  <= init_rem;
            vec_q  <= lk_vec;
            base_q <= lk_base;
            ew_q   <= lk_ew;
            busy_q <= |init_rem;
            done_q <= ~|init_rem;
         end else if (fire) begin
            rem_q <= rem_nxt;
            if (rem_nxt == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;

   // R9: offered operation held while the queue stalls
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> op_valid && $stable(op_idx)
                               && $stable(op_preg) && $stable(op_boff));

   // R5: strictly ascending indices inside one instruction
   p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ready |=> !op_valid || (op_idx > $past(op_idx)));

   // R8: done only while idle
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !op_valid);

   // R1: busy persists until an operation is taken
   p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !op_ready |=> busy);

   // R10: captured operand state frozen while running
   p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(base_q) && $stable(vec_q) && $stable(ew_q));

   // R5: no idle cycle while elements remain
   p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> op_valid);
endmodule

// File: tb/sim_vseq_issue.sv
module sim_vseq_issue;
   localparam int TCLK = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [6:0]    vlen = '0;
   logic [63:0]   pmask = '0;
   logic [14:0]   areg = '0;
   logic [31:0]   t_vec = '0;
   logic [223:0]  t_red = '0;
   logic [63:0]   t_ew = '0;
   logic          busy, done, op_valid;
   logic          op_ready = 1'b0;
   logic [5:0]    op_idx;
   logic [20:0]   op_preg;
   logic [8:0]    op_boff;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #(TCLK/2) clk = ~clk;

   vseq_issue u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .pmask(pmask),
      .areg(areg), .tag_vec(t_vec), .tag_redir(t_red), .tag_ew(t_ew),
      .busy(busy), .done(done), .op_valid(op_valid), .op_ready(op_ready),
      .op_idx(op_idx), .op_preg(op_preg), .op_boff(op_boff)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_tag(input int r, input bit v, input int red, input int e);
      t_vec[r]         = v;
      t_red[r*7 +: 7]  = 7'(red);
      t_ew[r*2 +: 2]   = 2'(e);
   endtask

   // operand registers: op0 = r2, op1 = r5, op2 = r9
   task automatic run(input int vl, input logic [63:0] m, input bit disturb);
      int  lst[64];
      int  n = 0;
      bit  ev[3];
      int  eb[3];
      int  ee[3];
      int  regs[3] = '{2, 5, 9};
      bit  anyv = 0;
      bit  stalled = 0;
      logic [35:0] held = '0;
      int  ptr = 0;
      int  vlc = (vl > 64) ? 64 : vl;
      for (int k = 0; k < 3; k++) begin
         ev[k] = t_vec[regs[k]];
         eb[k] = int'(t_red[regs[k]*7 +: 7]);
         ee[k] = int'(t_ew[regs[k]*2 +: 2]);
         anyv |= ev[k];
      end
      if (!anyv) begin
         lst[0] = 0; n = 1;
      end else begin
         for (int i = 0; i < vlc; i++) if (m[i]) begin lst[n] = i; n++; end
      end
      areg  = {5'(9), 5'(5), 5'(2)};
      vlen  = 7'(vl);
      pmask = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (ptr < n) begin
         chk(op_valid === 1'b1, "R5 valid", int'(op_valid), 1);
         chk(busy === 1'b1, "R1 busy", int'(busy), 1);
         chk(int'(op_idx) == lst[ptr], "R5 index", int'(op_idx), lst[ptr]);
         for (int k = 0; k < 3; k++) begin
            int xp = ev[k] ? ((eb[k] + (lst[ptr] >> ee[k])) & 127) : eb[k];
            int xb = ev[k] ? ((lst[ptr] * (8 >> ee[k])) & 7) : 0;
            chk(int'(op_preg[k*7 +: 7]) == xp, ev[k] ? "R2 preg" : "R4 preg",
                int'(op_preg[k*7 +: 7]), xp);
            chk(int'(op_boff[k*3 +: 3]) == xb, ev[k] ? "R3 boff" : "R4 boff",
                int'(op_boff[k*3 +: 3]), xb);
         end
         if (stalled)
            chk({op_idx, op_preg, op_boff} == held, "R9 stable",
                int'({op_idx, op_preg[6:0]}), int'({held[35:30], held[15:9]}));
         if (disturb && ptr == 0 && !stalled) begin
            // R1 / R10: offer a new instruction and rewrite tags mid-run
            start = 1'b1;
            vlen  = 7'd3;
            set_tag(2, 1'b1, 11, 3);
            set_tag(9, 1'b1, 40, 1);
         end
         held     = {op_idx, op_preg, op_boff};
         op_ready = ((cyc * 7 + 3) % 5) != 0;
         stalled  = !op_ready;
         cyc++;
         @(negedge clk);
         start = 1'b0;
         if (!stalled) ptr++;
      end
      op_ready = 1'b0;
      chk(op_valid === 1'b0, "R8 valid low", int'(op_valid), 0);
      chk(busy === 1'b0, "R8 busy low", int'(busy), 0);
      chk(done === 1'b1, n == 0 ? "R7 done" : "R8 done", int'(done), 1);
      @(negedge clk);
      chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
   endtask

   task automatic finish_up;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
      int vls[4] = '{1, 7, 16, 64};
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
      chk(op_valid === 1'b0, "R1 reset valid", int'(op_valid), 0);
      chk(done === 1'b0, "R8 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int e0 = 0; e0 < 4; e0++) begin
         for (int v = 0; v < 4; v++) begin
            for (int p = 0; p < 3; p++) begin
               logic [63:0] m;
               set_tag(2, 1'b1, 120, e0);
               set_tag(5, 1'b1, 120, (e0 + 1) % 4);
               set_tag(9, 1'b0, 77, 3);
               lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
               m = (p == 0) ? '1 : (p == 1) ? {32{2'b10}} : lf;
               run(vls[v], m, 1'b0);
            end
         end
      end
      // R7: nothing enabled
      run(20, 64'hFFFF_FFFF_FFF0_0000, 1'b0);
      run(0, '1, 1'b0);
      // R6: no operand vectorised, mask and length ignored
      set_tag(2, 1'b0, 33, 3);
      set_tag(5, 1'b0, 33, 2);
      set_tag(9, 1'b0, 34, 1);
      run(0, '0, 1'b0);
      run(64, '1, 1'b0);
      // R1 and R10: start and tag writes while busy are ignored
      set_tag(2, 1'b1, 126, 2);
      set_tag(5, 1'b0, 3, 0);
      set_tag(9, 1'b1, 60, 0);
      run(12, 64'h0000_0000_0000_0B6D, 1'b1);
      // R2: ew 64 walks whole registers with wrap at 127
      set_tag(2, 1'b1, 125, 0);
      set_tag(5, 1'b1, 0, 3);
      set_tag(9, 1'b1, 125, 0);
      run(9, '1, 1'b0);
      finish_up();
   end
endmodule